// File: doc/BRIEF.md
# Overflow Timer with Sticky Interrupt Flag

This block is an up counter that advances by one on every cycle in which a count-enable tick is high. When the counter rolls over from its all-ones value to zero, it sets a sticky overflow flag. The flag behaves like an extra top bit that only hardware overflow can raise. Software clears it by writing a one to it, and the interrupt vectoring logic clears it with an acknowledge pulse.

A small register port lets software read or preload the counter at any time, whether or not ticks are arriving. The same port sets an overflow interrupt mask and clears the flag. An interrupt request is raised while the flag, the mask and a global interrupt enable are all high. A register write to the counter always takes precedence over a tick in the same cycle.

Top module: `ovf_timer`

## Requirements
- R1: After reset the counter, the mask bit and the overflow flag are all zero, and `irq` is low.
- R2: A cycle with `tick` high and no counter write adds one to `count` at the next edge. A cycle with neither leaves `count` unchanged.
- R3: On a tick with `count` at all ones and no counter write, `count` becomes zero and `ovf_flag` becomes one at the same edge.
- R4: Once set, `ovf_flag` stays set through further ticks and further wraps until one of the clears in R6 or R7 occurs.
- R5: A write to address 0 loads `wdata` into `count` at the next edge, even when a tick is high in the same cycle. Such a cycle never sets the flag, even with `count` at all ones.
- R6: A write to address 2 with `wdata[0]`=1 clears `ovf_flag` at the next edge. A write there with `wdata[0]`=0 leaves the flag unchanged.
- R7: A one-cycle `irq_ack` pulse clears `ovf_flag` at the next edge.
- R8: If a wrap (R3) occurs in the same cycle as a clear (R6 or R7), the flag ends up set.
- R9: `irq` is high exactly when `global_ie`, the mask bit and `ovf_flag` are all one.
- R10: A write to address 1 stores `wdata[0]` as the mask bit.
- R11: `rdata` returns, without delay, the value at `addr`. Address 0 gives the counter. Address 1 gives the mask in bit 0. Address 2 gives the flag in bit 0. Address 3 gives zero. All unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable, one increment per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 counter, 1 mask, 2 flag) |
| wdata | input | W | Write data |
| rdata | output | W | Read data for `addr` |
| global_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| count | output | W | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench uses the default width W=8, so a wrap happens every 256 ticks. A full free-running pass from zero to a second wrap takes a few hundred cycles, which is short enough to check the sticky behaviour across two overflows. Preloading the counter to values near all ones brings the edge cases within a few cycles. These cases are a write colliding with a tick at the top value, and a wrap coinciding with an acknowledge or a software clear.

// File: rtl/ovf_timer.sv
module ovf_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         global_ie,
  input  logic         irq_ack,
  output logic [W-1:0] count,
  output logic         ovf_flag,
  output logic         irq
);

  localparam logic [1:0]   A_CNT  = 2'd0;
  localparam logic [1:0]   A_MASK = 2'd1;
  localparam logic [1:0]   A_FLAG = 2'd2;
  localparam logic [W-1:0] TOP    = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         mask_q;
  logic         flag_q;

  wire cnt_wr   = wr_en && (addr == A_CNT);
  wire mask_wr  = wr_en && (addr == A_MASK);
  wire flag_clr = irq_ack || (wr_en && (addr == A_FLAG) && wdata[0]);
  wire wrap     = tick && !cnt_wr && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_wr)
      cnt_q <= wdata;
    else if (tick)
      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= 1'b0;
    else if (mask_wr)
      mask_q <= wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (wrap)
      flag_q <= 1'b1;
    else if (flag_clr)
      flag_q <= 1'b0;
  end

  always_comb begin
    case (addr)
      A_CNT:   rdata = cnt_q;
      A_MASK:  rdata = {{(W-1){1'b0}}, mask_q};
      A_FLAG:  rdata = {{(W-1){1'b0}}, flag_q};
      default: rdata = '0;
    endcase
  end

  assign count    = cnt_q;
  assign ovf_flag = flag_q;
  assign irq      = global_ie & mask_q & flag_q;

endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         wr_en,
  input logic [1:0]   addr,
  input logic [W-1:0] wdata,
  input logic         global_ie,
  input logic         irq_ack,
  input logic [W-1:0] count,
  input logic         ovf_flag,
  input logic         irq
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  // R2
  inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(wr_en && addr == 2'd0) && count != TOP) |=> count == W'($past(count) + 1'b1));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !(wr_en && addr == 2'd0)) |=> $stable(count));

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(wr_en && addr == 2'd0) && count == TOP) |=> (count == '0 && ovf_flag));

  // R5
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0) |=> count == $past(wdata));

  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !irq_ack && !(wr_en && addr == 2'd2 && wdata[0])) |=> ovf_flag);

  // R7
  ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(tick && count == TOP)) |=> !ovf_flag);

  // R9
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ovf_flag && global_ie));

endmodule

bind ovf_timer ovf_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .global_ie(global_ie), .irq_ack(irq_ack),
  .count(count), .ovf_flag(ovf_flag), .irq(irq)
);

// File: tb/tb_ovf_timer.sv
module tb_ovf_timer;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam int TOPV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   addr = 2'd0;
  logic [W-1:0] wdata = '0;
  logic         global_ie = 1'b0;
  logic         irq_ack = 1'b0;
  logic [W-1:0] rdata;
  logic [W-1:0] count;
  logic         ovf_flag;
  logic         irq;

  int n_cmp = 0;
  int n_bad = 0;
  int m_cnt = 0;
  int m_mask = 0;
  int m_flag = 0;

  ovf_timer #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .global_ie(global_ie), .irq_ack(irq_ack),
    .count(count), .ovf_flag(ovf_flag), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input bit t, input bit w, input int a,
                     input int d, input bit ack, input bit ge);
    int nc;
    int nf;
    tick = t; wr_en = w; addr = a[1:0]; wdata = d[W-1:0];
    irq_ack = ack; global_ie = ge;
    #1;
    chk("R9 irq", int'(irq), (ge && m_mask == 1 && m_flag == 1) ? 1 : 0);
    case (a)
      0: chk("R11 rdata", int'(rdata), m_cnt);
      1: chk("R11 rdata", int'(rdata), m_mask);
      2: chk("R11 rdata", int'(rdata), m_flag);
      default: chk("R11 rdata", int'(rdata), 0);
    endcase
    nc = m_cnt; nf = m_flag;
    if (w && a == 0) nc = d;
    else if (t) nc = (m_cnt + 1) % (TOPV + 1);
    if (t && !(w && a == 0) && m_cnt == TOPV) nf = 1;
    else if (ack || (w && a == 2 && d[0])) nf = 0;
    if (w && a == 1) m_mask = d & 1;
    m_cnt = nc; m_flag = nf;
    @(posedge clk); #1;
    chk({tag, " count"}, int'(count), m_cnt);
    chk({tag, " flag"}, int'(ovf_flag), m_flag);
    tick = 0; wr_en = 0; irq_ack = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count", int'(count), 0);
    chk("R1 flag", int'(ovf_flag), 0);
    chk("R1 irq", int'(irq), 0);
    addr = 2'd1; #1;
    chk("R1 mask", int'(rdata), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int i = 0; i < 5; i++) cyc("R2", 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R2", 0, 0, 3, 0, 0, 0);
    cyc("R5", 1, 1, 0, TOPV - 2, 0, 0);
    cyc("R2", 1, 0, 0, 0, 0, 0);
    cyc("R2", 1, 0, 0, 0, 0, 0);
    cyc("R3", 1, 0, 2, 0, 0, 0);
    for (int i = 0; i < 260; i++) cyc("R4", 1, 0, i % 4, 0, 0, 0);
    cyc("R10", 0, 1, 1, 1, 0, 1);
    cyc("R9", 0, 0, 1, 0, 0, 1);
    cyc("R9", 0, 0, 2, 0, 0, 0);
    cyc("R6", 0, 1, 2, 'hFE, 0, 1);
    cyc("R6", 0, 1, 2, 1, 0, 1);
    cyc("R6", 0, 0, 2, 0, 0, 1);
    cyc("R5", 0, 1, 0, TOPV, 0, 1);
    cyc("R3", 1, 0, 0, 0, 0, 1);
    cyc("R7", 0, 0, 2, 0, 1, 1);
    cyc("R7", 0, 0, 2, 0, 0, 1);
    cyc("R5", 0, 1, 0, TOPV, 0, 1);
    cyc("R8", 1, 0, 2, 0, 1, 1);
    cyc("R7", 0, 0, 2, 0, 1, 1);
    cyc("R5", 0, 1, 0, TOPV, 0, 1);
    cyc("R8", 1, 1, 2, 1, 0, 1);
    cyc("R6", 0, 1, 2, 1, 0, 1);
    cyc("R5", 0, 1, 0, TOPV, 0, 1);
    cyc("R5", 1, 1, 0, 'h10, 0, 1);
    cyc("R10", 0, 1, 1, 'hFE, 0, 1);
    cyc("R11", 0, 0, 3, 0, 0, 1);
    cyc("R11", 0, 0, 0, 0, 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule